// File: doc/BRIEF.md
# Tournament Branch Direction and Return Target Predictor

This block predicts, at fetch time, whether a conditional branch will be taken. It also predicts the target of a return. Two tables of two-bit saturating counters run side by side. The local table is indexed by the branch address alone. The history table is indexed by the branch address XOR-ed with a shift register of recent resolved outcomes. For each branch address, a third table of two-bit chooser counters picks which of the two tables supplies the prediction. The chooser learns from the cases where the two tables disagreed.

A lookup presents a fetch address with call and return flags. The prediction is combinational in the same cycle. A resolve update presents the address of a conditional branch and its actual outcome. It trains all three tables and the history register at the next clock edge. Call lookups push the address of the following instruction onto a 16-entry circular return stack. Return lookups pop that stack and expose its top entry as the predicted target.

Top module: `tp_predictor`

## Requirements
- R1: After reset, every lookup predicts not-taken and a return lookup reports no valid target.
- R2: The local table has one two-bit counter per value of lk_pc[11:2]. Each counter resets to 1, adds 1 on a taken update and subtracts 1 on a not-taken update, saturating at 0 and 3. A value of 2 or more means taken.
- R3: The history table has the same counters. It is indexed by PC[11:2] XOR the 10-bit history register.
- R4: Every resolve update shifts its outcome into bit 0 of the history register; without an update the history holds.
- R5: The chooser counter at PC[11:2] resets to 1 and selects the history table when it is 2 or more. On an update where the two tables disagree, it steps up if the history table was right and down if the local table was right, saturating at 0 and 3. When they agree, it is unchanged.
- R6: A lookup and an update in the same cycle, even to the same entries, make the lookup return the values held before that update.
- R7: A valid lookup with the call flag pushes lk_pc+4 onto the return stack.
- R8: A valid lookup with only the return flag, when the stack holds entries, gives pr_tgt_valid=1 and pr_tgt equal to the most recently pushed entry, and pops it.
- R9: The stack keeps the 16 most recent pushes. A push onto a full stack overwrites the oldest entry.
- R10: A return lookup on an empty stack gives pr_tgt_valid=0 and pr_tgt=0, and the stack stays empty.
- R11: With lk_valid=0 the call and return flags have no effect, and pr_taken and pr_tgt_valid are 0.
- R12: A lookup with both flags set only pushes, and reports no target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_pc | input | 32 | Fetch address of the lookup |
| lk_is_call | input | 1 | Lookup is a call |
| lk_is_ret | input | 1 | Lookup is a return |
| up_valid | input | 1 | Resolve update present this cycle |
| up_pc | input | 32 | Address of the resolved conditional branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |
| pr_taken | output | 1 | Predicted direction |
| pr_tgt_valid | output | 1 | Return target prediction is valid |
| pr_tgt | output | 32 | Predicted return target |

## Verification
A lookup and a resolve update can arrive in the same cycle and touch the same counters. The bench presents both in one cycle on an address whose counters are still at their reset values. It expects the lookup to see the untrained not-taken value. In the following cycle it expects the trained value. The same overlap runs through every training loop, where each iteration both looks up and updates one branch, and a reference model of the tables judges each prediction.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LO = 2'd1;
  localparam ctr2_t CTR_MAX     = 2'd3;
  localparam ctr2_t CTR_MIN     = 2'd0;

  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
    ctr2_t res;
    if (up) res = (cur == CTR_MAX) ? cur : cur + 2'd1;
    else    res = (cur == CTR_MIN) ? cur : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int           IDX_W   = 10,
  parameter logic [1:0]   RST_VAL = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output tp_pkg::ctr2_t     rd_a_val,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output tp_pkg::ctr2_t     rd_b_val,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_inc
);
  import tp_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;

  ctr2_t mem [ENTRIES];
  ctr2_t wr_nxt;

  always_comb begin
    rd_a_val = mem[rd_a_idx];
    rd_b_val = mem[rd_b_idx];
    wr_nxt   = ctr_step(mem[wr_idx], wr_inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= RST_VAL;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_nxt;
    end
  end

  // R2: saturation at the top and bottom of the counter range
  a_r2_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_inc && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX);
  a_r2_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_inc && mem[wr_idx] == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN);

endmodule

// File: rtl/tp_ret_stack.sv
module tp_ret_stack #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_data,
  output logic            top_valid,
  output logic [PC_W-1:0] top_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [PC_W-1:0]  stk [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_pop;

  always_comb begin
    top_valid = (cnt_q != '0);
    top_data  = top_valid ? stk[wr_ptr_q - PTR_W'(1)] : '0;
    do_pop    = pop && !push && top_valid;
    wr_ptr_d  = wr_ptr_q;
    cnt_d     = cnt_q;
    if (push) begin
      wr_ptr_d = wr_ptr_q + PTR_W'(1);
      if (cnt_q != CNT_FULL) cnt_d = cnt_q + CNT_W'(1);
    end else if (do_pop) begin
      wr_ptr_d = wr_ptr_q - PTR_W'(1);
      cnt_d    = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) stk[wr_ptr_q] <= push_data;
  end

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt_q == CNT_FULL) |=> cnt_q == CNT_FULL);
  a_r7_push_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt_q != CNT_FULL) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r10_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> cnt_q == '0);
  a_r12_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (top_valid && top_data == $past(push_data)));

endmodule

// File: rtl/tp_predictor.sv
module tp_predictor #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 10,
  parameter int RAS_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_is_call,
  input  logic            lk_is_ret,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  output logic            pr_taken,
  output logic            pr_tgt_valid,
  output logic [PC_W-1:0] pr_tgt
);
  import tp_pkg::*;

  localparam int HIST_W = IDX_W;

  logic [HIST_W-1:0] ghr_q, ghr_d;
  logic [IDX_W-1:0]  lk_idx, up_idx, lk_gidx, up_gidx;
  ctr2_t loc_lk, loc_up, glb_lk, glb_up, sel_lk, sel_up;
  logic  loc_up_t, glb_up_t, comp_differ;
  logic  ras_push, ras_pop, ras_valid;
  logic [PC_W-1:0] ras_top;
  logic  unused_bits;

  always_comb begin
    lk_idx  = lk_pc[IDX_W+1:2];
    up_idx  = up_pc[IDX_W+1:2];
    lk_gidx = lk_idx ^ ghr_q;
    up_gidx = up_idx ^ ghr_q;
    loc_up_t    = loc_up[1];
    glb_up_t    = glb_up[1];
    comp_differ = up_valid && (loc_up_t != glb_up_t);
    ghr_d = up_valid ? {ghr_q[HIST_W-2:0], up_taken} : ghr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghr_q <= '0;
    else        ghr_q <= ghr_d;
  end

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LO)) loc_tab_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lk_idx), .rd_a_val(loc_lk),
    .rd_b_idx(up_idx), .rd_b_val(loc_up),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_inc(up_taken));

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LO)) glb_tab_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lk_gidx), .rd_a_val(glb_lk),
    .rd_b_idx(up_gidx), .rd_b_val(glb_up),
    .wr_en(up_valid), .wr_idx(up_gidx), .wr_inc(up_taken));

  // chooser: high half favours the history table
  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_LO)) sel_tab_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lk_idx), .rd_a_val(sel_lk),
    .rd_b_idx(up_idx), .rd_b_val(sel_up),
    .wr_en(comp_differ), .wr_idx(up_idx), .wr_inc(glb_up_t == up_taken));

  always_comb begin
    ras_push = lk_valid && lk_is_call;
    ras_pop  = lk_valid && lk_is_ret && !lk_is_call;
  end

  tp_ret_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) ras_i (
    .clk(clk), .rst_n(rst_n),
    .push(ras_push), .pop(ras_pop), .push_data(lk_pc + PC_W'(4)),
    .top_valid(ras_valid), .top_data(ras_top));

  always_comb begin
    pr_taken     = lk_valid && (sel_lk[1] ? glb_lk[1] : loc_lk[1]);
    pr_tgt_valid = ras_pop && ras_valid;
    pr_tgt       = pr_tgt_valid ? ras_top : '0;
  end

  assign unused_bits = ^{up_pc[PC_W-1:IDX_W+2], up_pc[1:0], lk_pc[1:0], sel_up};

  a_r4_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghr_q == {$past(ghr_q[HIST_W-2:0]), $past(up_taken)});
  a_r4_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghr_q));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!pr_taken && !pr_tgt_valid));
  a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_tgt_valid |-> pr_tgt == '0);

endmodule

// File: tb/tp_predictor_tb.sv
`timescale 1ns/1ps
module tp_predictor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_is_call, lk_is_ret, up_valid, up_taken;
  logic [31:0] lk_pc, up_pc;
  logic        pr_taken, pr_tgt_valid;
  logic [31:0] pr_tgt;

  int checks = 0;
  int errors = 0;

  // reference state built from the requirements
  int          m_loc [1024];
  int          m_glb [1024];
  int          m_sel [1024];
  int          m_ghr;
  logic [31:0] m_ras [16];
  int          m_top, m_cnt;

  always #2.5 clk = ~clk;

  tp_predictor dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_is_call(lk_is_call), .lk_is_ret(lk_is_ret),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .pr_taken(pr_taken), .pr_tgt_valid(pr_tgt_valid), .pr_tgt(pr_tgt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic int sat(input int v, input bit up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) begin
      m_loc[i] = 1; m_glb[i] = 1; m_sel[i] = 1;
    end
    m_ghr = 0; m_top = 0; m_cnt = 0;
  endtask

  // one cycle: drive, compare the combinational prediction, clock, advance model
  task automatic cyc(input string req, input bit lv, input logic [31:0] lpc,
                     input bit call, input bit ret, input bit uv,
                     input logic [31:0] upc, input bit ut);
    int li, ui, gi, gu;
    bit e_t, e_v, lp, gp;
    logic [31:0] e_tg;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc; lk_is_call = call; lk_is_ret = ret;
    up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    li = (lpc >> 2) & 1023;
    gi = li ^ m_ghr;
    e_t  = lv && ((m_sel[li] >= 2) ? (m_glb[gi] >= 2) : (m_loc[li] >= 2));
    e_v  = lv && ret && !call && (m_cnt > 0);
    e_tg = e_v ? m_ras[(m_top + 15) % 16] : 32'h0;
    chk({req, " taken"}, {31'b0, pr_taken}, {31'b0, e_t});
    chk({req, " tgt_valid"}, {31'b0, pr_tgt_valid}, {31'b0, e_v});
    chk({req, " tgt"}, pr_tgt, e_tg);
    @(posedge clk);
    if (uv) begin
      ui = (upc >> 2) & 1023;
      gu = ui ^ m_ghr;
      lp = m_loc[ui] >= 2;
      gp = m_glb[gu] >= 2;
      if (lp != gp) m_sel[ui] = sat(m_sel[ui], gp == ut);
      m_loc[ui] = sat(m_loc[ui], ut);
      m_glb[gu] = sat(m_glb[gu], ut);
      m_ghr = ((m_ghr << 1) | int'(ut)) & 1023;
    end
    if (lv && call) begin
      m_ras[m_top] = lpc + 32'd4;
      m_top = (m_top + 1) % 16;
      if (m_cnt < 16) m_cnt++;
    end else if (lv && ret && m_cnt > 0) begin
      m_top = (m_top + 15) % 16;
      m_cnt--;
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) cyc("R1", 1, 32'h1000 + i * 52, 0, 0, 0, 0, 0);
    cyc("R1", 1, 32'h40, 0, 1, 0, 0, 0);
    chk("R1 empty ret", {31'b0, pr_tgt_valid}, 32'h0);
  endtask

  task automatic t_local_sat();
    for (int i = 0; i < 5; i++) cyc("R2", 1, 32'h100, 0, 0, 1, 32'h100, 1);
    cyc("R2", 1, 32'h100, 0, 0, 1, 32'h100, 0);
    cyc("R2", 1, 32'h100, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R2", 1, 32'h180, 0, 0, 1, 32'h180, 0);
    cyc("R2", 1, 32'h180, 0, 0, 1, 32'h180, 1);
    cyc("R2", 1, 32'h180, 0, 0, 0, 0, 0);
  endtask

  task automatic t_global();
    int good = 0;
    for (int i = 0; i < 40; i++) begin
      bit o = (i % 2) == 0;
      cyc("R3 R4 R5", 1, 32'h200, 0, 0, 1, 32'h200, o);
      if (i >= 30 && pr_taken == o) good++;
    end
    chk("R5 history table chosen", good, 10);
    for (int i = 0; i < 8; i++) cyc("R4", 1, 32'h200, 0, 0, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    cyc("R6", 1, 32'h3F0, 0, 0, 1, 32'h3F0, 1);
    chk("R6 pre-update value", {31'b0, pr_taken}, 32'h0);
    cyc("R6", 1, 32'h3F0, 0, 0, 1, 32'h3F0, 1);
    cyc("R6", 1, 32'h3F0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_ras();
    cyc("R7", 1, 32'h500, 1, 0, 0, 0, 0);
    cyc("R7", 1, 32'h600, 1, 0, 0, 0, 0);
    cyc("R11", 0, 32'h700, 1, 0, 0, 0, 0);
    cyc("R8", 1, 32'h900, 0, 1, 0, 0, 0);
    chk("R8 last push", pr_tgt, 32'h604);
    cyc("R11", 0, 32'h900, 0, 1, 0, 0, 0);
    cyc("R8", 1, 32'h900, 0, 1, 0, 0, 0);
    chk("R8 second pop", pr_tgt, 32'h504);
    cyc("R10", 1, 32'h900, 0, 1, 0, 0, 0);
    chk("R10 underflow", {31'b0, pr_tgt_valid}, 32'h0);
    cyc("R10", 1, 32'h900, 0, 1, 0, 0, 0);
    for (int i = 0; i < 18; i++) cyc("R9", 1, 32'h2000 + i * 16, 1, 0, 0, 0, 0);
    for (int i = 17; i >= 2; i--) begin
      cyc("R9", 1, 32'hA00, 0, 1, 0, 0, 0);
      chk("R9 lifo", pr_tgt, 32'h2004 + i * 16);
    end
    cyc("R9", 1, 32'hA00, 0, 1, 0, 0, 0);
    chk("R9 oldest dropped", {31'b0, pr_tgt_valid}, 32'h0);
    cyc("R12", 1, 32'hC00, 1, 1, 0, 0, 0);
    chk("R12 no target", {31'b0, pr_tgt_valid}, 32'h0);
    cyc("R12", 1, 32'hD00, 0, 1, 0, 0, 0);
    chk("R12 pushed", pr_tgt, 32'hC04);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 0; lk_pc = 0; lk_is_call = 0; lk_is_ret = 0;
    up_valid = 0; up_pc = 0; up_taken = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_local_sat();
    t_global();
    t_same_cycle();
    t_ras();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule